// File: doc/BRIEF.md
# DMA Request Register Interface

This block is the software-facing side of a single-channel DMA engine. Software programs addresses, lengths, strides and flags into 32-bit registers, then writes the start register to queue a request. The block tags each queued request with a hardware-allocated 5-bit ID and holds it in a small queue. It hands requests one at a time to an external data mover through a valid/ready handshake. When the mover reports that an ID has finished, a per-ID done bitmap records it.

Two interrupt causes exist. A start event means a queued request went to the mover and a queue slot is free. An end event means a transfer completed. Each cause has a pending bit and a mask bit, and the block drives one interrupt line from them.

Software discovers the engine's length limits by writing to the X length register and reading the value back.

Top module: `dmareq_ctrl`

## Requirements
- R1: After reset: control reads 0, the interrupt mask reads 3 (both causes masked), pending reads 0, next-ID reads 0, the done register reads 0, start reads 0 and `irq` is low.
- R2: Reading the start register (0x408) returns 1 while the queue holds QDEPTH requests and 0 otherwise. A submit while the queue is full is dropped and does not advance the ID.
- R3: Writing 1 to bit 0 of the start register while enabled queues the programmed request. The request gets the ID read from 0x404, and that register then advances modulo 32. The done bit of the ID being allocated clears in the same cycle.
- R4: Queued requests leave in submission order. Each carries its ID, flags, addresses, lengths and strides as they were programmed at submit time. `req_valid` is high only while control bit 0 (enable) is 1 and control bit 1 (pause) is 0. While `req_ready` is low the presented request does not change.
- R5: A `done_valid` pulse with ID N sets bit N of the done register (0x428) for N from 0 to 30. In the same clock edge it sets pending bit 1 (end of transfer). ID 31 raises only the pending bit.
- R6: The clock edge on which the mover accepts a request (`req_valid` and `req_ready` both high) sets pending bit 0 (start of transfer).
- R7: Writing ones to the pending register (0x84) clears those pending bits. A new event in the same cycle wins over the clear.
- R8: `irq` is high when any pending bit is set whose mask bit (0x80) is 0. The source register (0x88) reads pending AND NOT mask.
- R9: Writing control with bit 0 clear empties the queue. Submits while disabled are ignored.
- R10: A write to X length (0x418) stores the value with the alignment bits forced to 1, limited to LEN_W bits. With the defaults, writing 0 reads back 3 and writing all ones reads back 0x00FFFFFF.
- R11: Bit 31 of the done register is set by a completion that arrives with `done_partial` high. Writing a 1 to bit 31 of the done register clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| req_valid | output | 1 | Request presented to the data mover |
| req_ready | input | 1 | Mover accepts the request |
| req_id | output | 5 | ID of the presented request |
| req_flags | output | 3 | Cyclic, last and partial-report flags |
| req_dst | output | 32 | Destination address |
| req_src | output | 32 | Source address |
| req_xlen | output | 32 | X length minus one |
| req_ylen | output | 32 | Y length minus one |
| req_dstride | output | 32 | Destination stride |
| req_sstride | output | 32 | Source stride |
| done_valid | input | 1 | Mover reports a finished request |
| done_id | input | 5 | ID of the finished request |
| done_partial | input | 1 | Finished request ended short |
| irq | output | 1 | Interrupt line |

## Verification
Read data is combinational, so a register's value can be sampled in the same cycle the read strobe is driven. A register write, a submit, a mover accept or a done pulse takes effect on the one rising edge that samples the strobe. The new register contents, pending bits, `irq` level and presented request are therefore due one edge after the stimulus. The bench drives every strobe at a falling edge, holds it across exactly one rising edge, and samples at the next falling edge. Each check thus lands one cycle after its cause and never on an edge.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
   localparam int ID_W    = 5;
   localparam int NUM_IDS = 1 << ID_W;
   localparam int FLAG_W  = 3;
   localparam int NSRC    = 2;
   localparam int SRC_SOT = 0;
   localparam int SRC_EOT = 1;

   localparam logic [11:0] OFS_IMASK   = 12'h080;
   localparam logic [11:0] OFS_IPEND   = 12'h084;
   localparam logic [11:0] OFS_ISRC    = 12'h088;
   localparam logic [11:0] OFS_CONTROL = 12'h400;
   localparam logic [11:0] OFS_NEXTID  = 12'h404;
   localparam logic [11:0] OFS_START   = 12'h408;
   localparam logic [11:0] OFS_FLAGS   = 12'h40C;
   localparam logic [11:0] OFS_DST     = 12'h410;
   localparam logic [11:0] OFS_SRC     = 12'h414;
   localparam logic [11:0] OFS_XLEN    = 12'h418;
   localparam logic [11:0] OFS_YLEN    = 12'h41C;
   localparam logic [11:0] OFS_DSTRIDE = 12'h420;
   localparam logic [11:0] OFS_SSTRIDE = 12'h424;
   localparam logic [11:0] OFS_DONE    = 12'h428;

   typedef struct packed {
      logic [ID_W-1:0]   id;
      logic [FLAG_W-1:0] flags;
      logic [31:0]       dst;
      logic [31:0]       src;
      logic [31:0]       xlen;
      logic [31:0]       ylen;
      logic [31:0]       dstride;
      logic [31:0]       sstride;
   } dmareq_t;
endpackage

// File: rtl/dmareq_fifo.sv
module dmareq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   input  logic         flush_i,
   output logic [W-1:0] data_o,
   output logic         full_o,
   output logic         empty_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("dmareq_fifo: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("dmareq_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full_o  = (count == CW'(DEPTH));
   assign empty_o = (count == '0);
   assign data_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_i && !flush_i) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_i) wr_ptr <= bump(wr_ptr);
         if (pop_i)  rd_ptr <= bump(rd_ptr);
         count <= count + CW'(push_i) - CW'(pop_i);
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && full_o && !pop_i && !flush_i));
   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
endmodule

// File: rtl/dmareq_idtrack.sv
module dmareq_idtrack #(
   parameter int ID_W  = 5,
   parameter int MAP_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic             done_valid_i,
   input  logic [ID_W-1:0]  done_id_i,
   input  logic             done_partial_i,
   input  logic             partial_clr_i,
   output logic [ID_W-1:0]  next_id_o,
   output logic [MAP_W-1:0] done_map_o,
   output logic             partial_o
);
   generate
      if (MAP_W > (1 << ID_W) || MAP_W < 1) begin : g_bad_map
         $error("dmareq_idtrack: MAP_W must lie in 1 .. 2**ID_W");
      end
   endgenerate

   logic [ID_W-1:0]  next_q;
   logic [MAP_W-1:0] map_q;
   logic             part_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q <= '0;
         map_q  <= '0;
         part_q <= 1'b0;
      end else begin
         if (alloc_i) next_q <= next_q + 1'b1;
         for (int i = 0; i < MAP_W; i++) begin
            if (done_valid_i && done_id_i == ID_W'(i))
               map_q[i] <= 1'b1;
            else if (alloc_i && next_q == ID_W'(i))
               map_q[i] <= 1'b0;
         end
         if (done_valid_i && done_partial_i) part_q <= 1'b1;
         else if (partial_clr_i)             part_q <= 1'b0;
      end
   end

   assign next_id_o  = next_q;
   assign done_map_o = map_q;
   assign partial_o  = part_q;

   assert_id_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |=> next_id_o == $past(next_id_o) + 1'b1);
   assert_done_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid_i && int'(done_id_i) < MAP_W) |=> done_map_o[$past(done_id_i)]);
   assert_partial_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid_i && done_partial_i) |=> partial_o);
endmodule

// File: rtl/dmareq_irq.sv
module dmareq_irq #(
   parameter int N       = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] pending_o,
   output logic [N-1:0] source_o,
   output logic         irq_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("dmareq_irq: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_i) | set_i;
   end

   assign pending_o = pend_q;
   assign source_o  = pend_q & ~mask_i;

   generate
      if (REG_OUT) begin : g_reg_irq
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(((pend_q & ~clr_i) | set_i) & ~mask_i);
         end
         assign irq_o = irq_q;
      end else begin : g_comb_irq
         assign irq_o = |source_o;
      end
   endgenerate

   assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((pending_o & $past(set_i)) == $past(set_i)));
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((pending_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/dmareq_ctrl.sv
module dmareq_ctrl
   import dmareq_pkg::*;
#(
   parameter int REG_AW     = 12,
   parameter int LEN_W      = 24,
   parameter int ALIGN_BITS = 2,
   parameter int QDEPTH     = 2,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ID_W-1:0]   req_id,
   output logic [FLAG_W-1:0] req_flags,
   output logic [31:0]       req_dst,
   output logic [31:0]       req_src,
   output logic [31:0]       req_xlen,
   output logic [31:0]       req_ylen,
   output logic [31:0]       req_dstride,
   output logic [31:0]       req_sstride,
   input  logic              done_valid,
   input  logic [ID_W-1:0]   done_id,
   input  logic              done_partial,
   output logic              irq
);
   localparam logic [31:0] LEN_MASK   = (LEN_W >= 32) ? 32'hFFFF_FFFF
                                        : ((32'd1 << LEN_W) - 32'd1);
   localparam logic [31:0] ALIGN_MASK = (32'd1 << ALIGN_BITS) - 32'd1;
   localparam int          MAP_W      = NUM_IDS - 1;
   localparam int          REQ_W      = $bits(dmareq_t);

   generate
      if (REG_AW < 12) begin : g_bad_aw
         $error("dmareq_ctrl: REG_AW must cover offset 0x428");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("dmareq_ctrl: LEN_W must lie in 1 .. 32");
      end
      if (ALIGN_BITS < 0 || ALIGN_BITS >= LEN_W) begin : g_bad_align
         $error("dmareq_ctrl: ALIGN_BITS must be below LEN_W");
      end
   endgenerate

   logic [11:0] ofs;
   assign ofs = reg_addr[11:0];

   logic [2:0]        ctrl_q;
   logic [FLAG_W-1:0] flags_q;
   logic [31:0]       dst_q, src_q, xlen_q, ylen_q, dstr_q, sstr_q;
   logic [NSRC-1:0]   mask_q;

   logic en, paused;
   assign en     = ctrl_q[0];
   assign paused = ctrl_q[1];

   logic q_full, q_empty, submit, abort, pop;
   logic [ID_W-1:0]  next_id;
   logic [MAP_W-1:0] done_map;
   logic             partial_flag;
   dmareq_t          push_req, head_req;

   assign submit = reg_wr && ofs == OFS_START && reg_wdata[0] && en && !q_full;
   assign abort  = reg_wr && ofs == OFS_CONTROL && !reg_wdata[0];
   assign req_valid = !q_empty && en && !paused;
   assign pop       = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         flags_q <= '0;
         dst_q   <= '0;
         src_q   <= '0;
         xlen_q  <= ALIGN_MASK;
         ylen_q  <= '0;
         dstr_q  <= '0;
         sstr_q  <= '0;
         mask_q  <= '1;
      end else if (reg_wr) begin
         unique case (ofs)
            OFS_CONTROL: ctrl_q  <= reg_wdata[2:0];
            OFS_FLAGS:   flags_q <= reg_wdata[FLAG_W-1:0];
            OFS_DST:     dst_q   <= reg_wdata;
            OFS_SRC:     src_q   <= reg_wdata;
            OFS_XLEN:    xlen_q  <= (reg_wdata | ALIGN_MASK) & LEN_MASK;
            OFS_YLEN:    ylen_q  <= reg_wdata & LEN_MASK;
            OFS_DSTRIDE: dstr_q  <= reg_wdata;
            OFS_SSTRIDE: sstr_q  <= reg_wdata;
            OFS_IMASK:   mask_q  <= reg_wdata[NSRC-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      push_req         = '0;
      push_req.id      = next_id;
      push_req.flags   = flags_q;
      push_req.dst     = dst_q;
      push_req.src     = src_q;
      push_req.xlen    = xlen_q;
      push_req.ylen    = ylen_q;
      push_req.dstride = dstr_q;
      push_req.sstride = sstr_q;
   end

   logic [REQ_W-1:0] head_bits;

   dmareq_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (submit),
      .data_i  (push_req),
      .pop_i   (pop),
      .flush_i (abort),
      .data_o  (head_bits),
      .full_o  (q_full),
      .empty_o (q_empty)
   );

   assign head_req    = dmareq_t'(head_bits);
   assign req_id      = head_req.id;
   assign req_flags   = head_req.flags;
   assign req_dst     = head_req.dst;
   assign req_src     = head_req.src;
   assign req_xlen    = head_req.xlen;
   assign req_ylen    = head_req.ylen;
   assign req_dstride = head_req.dstride;
   assign req_sstride = head_req.sstride;

   logic part_clr;
   assign part_clr = reg_wr && ofs == OFS_DONE && reg_wdata[31];

   dmareq_idtrack #(.ID_W(ID_W), .MAP_W(MAP_W)) u_ids (
      .clk            (clk),
      .rst_n          (rst_n),
      .alloc_i        (submit),
      .done_valid_i   (done_valid),
      .done_id_i      (done_id),
      .done_partial_i (done_partial),
      .partial_clr_i  (part_clr),
      .next_id_o      (next_id),
      .done_map_o     (done_map),
      .partial_o      (partial_flag)
   );

   logic [NSRC-1:0] ev_set, ev_clr, pend, src_bits;
   always_comb begin
      ev_set          = '0;
      ev_set[SRC_SOT] = pop;
      ev_set[SRC_EOT] = done_valid;
      ev_clr = (reg_wr && ofs == OFS_IPEND) ? reg_wdata[NSRC-1:0] : '0;
   end

   dmareq_irq #(.N(NSRC), .REG_OUT(IRQ_REG)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (ev_set),
      .clr_i     (ev_clr),
      .mask_i    (mask_q),
      .pending_o (pend),
      .source_o  (src_bits),
      .irq_o     (irq)
   );

   logic [31:0] rd_mux;
   always_comb begin
      unique case (ofs)
         OFS_IMASK:   rd_mux = 32'(mask_q);
         OFS_IPEND:   rd_mux = 32'(pend);
         OFS_ISRC:    rd_mux = 32'(src_bits);
         OFS_CONTROL: rd_mux = 32'(ctrl_q);
         OFS_NEXTID:  rd_mux = 32'(next_id);
         OFS_START:   rd_mux = 32'(q_full);
         OFS_FLAGS:   rd_mux = 32'(flags_q);
         OFS_DST:     rd_mux = dst_q;
         OFS_SRC:     rd_mux = src_q;
         OFS_XLEN:    rd_mux = xlen_q;
         OFS_YLEN:    rd_mux = ylen_q;
         OFS_DSTRIDE: rd_mux = dstr_q;
         OFS_SSTRIDE: rd_mux = sstr_q;
         OFS_DONE:    rd_mux = {partial_flag, done_map};
         default:     rd_mux = '0;
      endcase
   end
   assign reg_rdata = reg_rd ? rd_mux : '0;

   assert_hold_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (!req_valid || $stable(req_id)));
   assert_sot_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> pend[SRC_SOT]);
   assert_eot_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> pend[SRC_EOT]);
   assert_abort_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !req_valid);
endmodule

// File: tb/tb_dmareq_ctrl.sv
module tb_dmareq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid, req_ready = 1'b0;
   logic [4:0]  req_id;
   logic [2:0]  req_flags;
   logic [31:0] req_dst, req_src, req_xlen, req_ylen, req_dstride, req_sstride;
   logic        done_valid = 1'b0;
   logic [4:0]  done_id = '0;
   logic        done_partial = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dmareq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
      .req_flags(req_flags), .req_dst(req_dst), .req_src(req_src),
      .req_xlen(req_xlen), .req_ylen(req_ylen), .req_dstride(req_dstride),
      .req_sstride(req_sstride), .done_valid(done_valid), .done_id(done_id),
      .done_partial(done_partial), .irq(irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #0.5;
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, $sformatf("reg 0x%03h", a), v, exp);
   endtask

   task automatic accept_one();
      @(negedge clk); req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
   endtask

   task automatic finish_one(input logic [4:0] id, input logic part);
      @(negedge clk); done_valid = 1'b1; done_id = id; done_partial = part;
      @(negedge clk); done_valid = 1'b0; done_partial = 1'b0;
   endtask

   task automatic t_reset();
      rdchk("R1", 12'h400, 32'h0);
      rdchk("R1", 12'h080, 32'h3);
      rdchk("R1", 12'h084, 32'h0);
      rdchk("R1", 12'h404, 32'h0);
      rdchk("R1", 12'h428, 32'h0);
      rdchk("R1", 12'h408, 32'h0);
      chk("R1", "irq", 32'(irq), 32'h0);
   endtask

   task automatic t_length_probe();
      wr(12'h418, 32'h0);          rdchk("R10", 12'h418, 32'h0000_0003);
      wr(12'h418, 32'hFFFF_FFFF);  rdchk("R10", 12'h418, 32'h00FF_FFFF);
      wr(12'h418, 32'h0000_0105);  rdchk("R10", 12'h418, 32'h0000_0107);
   endtask

   task automatic t_disabled_submit();
      wr(12'h408, 32'h1);
      rdchk("R9", 12'h404, 32'h0);
      chk("R9", "req_valid while disabled", 32'(req_valid), 32'h0);
   endtask

   task automatic t_queue_fill();
      wr(12'h400, 32'h1);
      wr(12'h410, 32'h0000_1000); wr(12'h414, 32'h0000_2000);
      wr(12'h418, 32'h0000_00FF); wr(12'h41C, 32'h0);
      wr(12'h420, 32'h40);        wr(12'h424, 32'h80);
      wr(12'h40C, 32'h2);
      wr(12'h408, 32'h1);
      rdchk("R3", 12'h404, 32'h1);
      rdchk("R2", 12'h408, 32'h0);
      chk("R4", "req_valid", 32'(req_valid), 32'h1);
      chk("R4", "req_id", 32'(req_id), 32'h0);
      chk("R4", "req_dst", req_dst, 32'h1000);
      chk("R4", "req_src", req_src, 32'h2000);
      chk("R4", "req_xlen", req_xlen, 32'hFF);
      chk("R4", "req_sstride", req_sstride, 32'h80);
      chk("R4", "req_flags", 32'(req_flags), 32'h2);
      wr(12'h410, 32'h0000_3000); wr(12'h40C, 32'h1);
      wr(12'h408, 32'h1);
      rdchk("R3", 12'h404, 32'h2);
      rdchk("R2", 12'h408, 32'h1);
      wr(12'h408, 32'h1);
      rdchk("R2", 12'h404, 32'h2);
      chk("R4", "head unchanged id", 32'(req_id), 32'h0);
      chk("R4", "head unchanged dst", req_dst, 32'h1000);
   endtask

   task automatic t_pause();
      wr(12'h400, 32'h3);
      chk("R4", "req_valid paused", 32'(req_valid), 32'h0);
      wr(12'h400, 32'h1);
      chk("R4", "req_valid resumed", 32'(req_valid), 32'h1);
   endtask

   task automatic t_start_irq();
      accept_one();
      rdchk("R6", 12'h084, 32'h1);
      chk("R4", "second id", 32'(req_id), 32'h1);
      chk("R4", "second dst", req_dst, 32'h3000);
      chk("R4", "second flags", 32'(req_flags), 32'h1);
      rdchk("R2", 12'h408, 32'h0);
      chk("R8", "irq masked", 32'(irq), 32'h0);
      wr(12'h080, 32'h2);
      chk("R8", "irq unmasked", 32'(irq), 32'h1);
      rdchk("R8", 12'h088, 32'h1);
      wr(12'h084, 32'h1);
      rdchk("R7", 12'h084, 32'h0);
      chk("R7", "irq after clear", 32'(irq), 32'h0);
   endtask

   task automatic t_done();
      finish_one(5'd0, 1'b0);
      rdchk("R5", 12'h428, 32'h1);
      rdchk("R5", 12'h084, 32'h2);
      chk("R8", "eot masked", 32'(irq), 32'h0);
      wr(12'h080, 32'h0);
      chk("R8", "eot unmasked", 32'(irq), 32'h1);
      finish_one(5'd1, 1'b1);
      rdchk("R11", 12'h428, 32'h8000_0003);
      wr(12'h428, 32'h8000_0000);
      rdchk("R11", 12'h428, 32'h0000_0003);
      accept_one();
      wr(12'h084, 32'h3);
      rdchk("R7", 12'h084, 32'h0);
   endtask

   task automatic t_wrap();
      req_ready = 1'b1;
      for (int i = 2; i < 32; i++) wr(12'h408, 32'h1);
      @(negedge clk);
      rdchk("R3", 12'h404, 32'h0);
      rdchk("R3", 12'h428, 32'h3);
      wr(12'h408, 32'h1);
      @(negedge clk);
      req_ready = 1'b0;
      rdchk("R3", 12'h404, 32'h1);
      rdchk("R3", 12'h428, 32'h2);
      wr(12'h084, 32'h3);
   endtask

   task automatic t_abort();
      wr(12'h408, 32'h1);
      wr(12'h408, 32'h1);
      rdchk("R2", 12'h408, 32'h1);
      wr(12'h400, 32'h0);
      chk("R9", "req_valid after abort", 32'(req_valid), 32'h0);
      rdchk("R9", 12'h408, 32'h0);
      wr(12'h400, 32'h1);
      chk("R9", "queue emptied", 32'(req_valid), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_length_probe();
      t_disabled_submit();
      t_queue_fill();
      t_pause();
      t_start_irq();
      t_done();
      t_wrap();
      t_abort();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule